// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Memory

This block is a memory of four independent banks, each one data word wide, reached over a narrow request bus. Its main job is to fill multi-word cache lines. A word address picks a bank through its two low bits. The remaining upper bits form the row inside that bank. Because neighbouring words sit in neighbouring banks, a line of up to four words touches each bank once. The block sends the row to every bank of the line in a single address phase. The bank access times then overlap, and the words come back one per transfer slot. The cost of a line is one address phase, plus one access time, plus one slot per word. It is not one full access per word.

Each bank counts down its own access time after every read or write issued to it. A new request that needs a bank still counting is held at the request handshake until that bank is free. Two accesses to one bank therefore never overlap. Accesses to different banks do overlap, most visibly for a stream of single-word writes. Read words are returned in ascending address order, each with a one-cycle valid strobe, and the final word of the line carries a last flag.

Top module: `interleaved_mem`

## Requirements
- R1: The bank of a word is its address modulo 4, and the row within the bank is the address divided by 4. Writing one address leaves every other address unchanged.
- R2: A read returns the words of its line in ascending address order, each equal to the last value written to that address.
- R3: Take the edge that accepts a read as edge 0. Word k of the line (k from 0) is presented with rsp_valid high for exactly one cycle, following edge 4+24+4*(k+1). A 1-word line therefore ends at edge 32, a 2-word line at 36 and a 4-word line at 44.
- R4: rsp_last is high with the final word of a line and low with every other word.
- R5: After a bank is issued an access, that bank is busy for 24 cycles. A request to the same bank accepted at edge E cannot be followed by another request to that bank earlier than edge E+29.
- R6: A write moves a single word. The block can accept its next request, provided that request needs a different, idle bank, 5 edges after accepting the write.
- R7: The line start is the request address with its low log2(length) bits cleared, so an unaligned address reads the aligned line that contains it.
- R8: req_len is a 2-bit length code: 0 selects 1 word, 1 selects 2 words, 2 and 3 both select 4 words. Writes ignore req_len.
- R9: During and right after reset, req_ready is high and rsp_valid is low.
- R10: A read is accepted only when every bank of its line is idle. No request is accepted while a read line is still being returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = single-word write, 0 = line read |
| req_addr | input | 8 | Word address |
| req_len | input | 2 | Line length code for reads |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read word present, one-cycle strobe |
| rsp_data | output | 32 | Read word |
| rsp_last | output | 1 | Final word of the line |

## Verification
The memory is first filled through a stream of writes at consecutive addresses. That stream rotates through the banks and shows the difference between a bank being reused (stall until its count ends) and a fresh bank (accepted five edges later). Directed reads of each length, at aligned and unaligned starts, separate the per-word latency from the alignment rule and the length decode. Write-then-read pairs on a shared bank show both the read stall and the data being current. A seeded random mix of reads and writes then compares every acceptance edge, word edge and word value against a bench model of bank and controller availability.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ADDR   = 2'd1,
        PH_ACCESS = 2'd2,
        PH_XFER   = 2'd3
    } ilv_phase_e;

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 64,
    parameter int ACC_CYC = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic                     issue_we,
    input  logic [$clog2(DEPTH)-1:0] row,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     busy,
    output logic [DATA_W-1:0]        rdata
);
    localparam int CW = $clog2(ACC_CYC + 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic [CW-1:0]     cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue) begin
            cnt_d = CW'(ACC_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (issue && issue_we) begin
            mem_q[row] <= wdata;
        end
        if (issue && !issue_we) begin
            rd_q <= mem_q[row];
        end
    end

    assign busy  = (cnt_q != '0);
    assign rdata = rd_q;

    // R5: the sequencer never starts a bank that is still counting
    assert_issue_on_idle_bank_R5: assert property (
        @(posedge clk) disable iff (!rst_n) issue |-> (cnt_q == '0));

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 2,
    parameter int ADDR_CYC = 4,
    parameter int ACC_CYC  = 24,
    parameter int XFER_CYC = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [LEN_W-1:0]                    req_len,
    input  logic [DATA_W-1:0]                   req_wdata,
    input  logic [NBANK-1:0]                    bank_busy,
    input  logic [NBANK-1:0][DATA_W-1:0]        bank_rdata,
    output logic [NBANK-1:0]                    issue_mask,
    output logic                                issue_we,
    output logic [ADDR_W-$clog2(NBANK)-1:0]     issue_row,
    output logic [DATA_W-1:0]                   issue_wdata,
    output logic                                rsp_valid,
    output logic [DATA_W-1:0]                   rsp_data,
    output logic                                rsp_last
);
    localparam int BB     = $clog2(NBANK);
    localparam int RW     = ADDR_W - BB;
    localparam int LGW    = $clog2(BB + 1);
    localparam int CMAX   = (ACC_CYC > ADDR_CYC) ?
                            ((ACC_CYC > XFER_CYC) ? ACC_CYC : XFER_CYC) :
                            ((ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC);
    localparam int CW     = $clog2(CMAX + 1);

    typedef struct packed {
        ilv_phase_e        phase;
        logic [CW-1:0]     cnt;
        logic              we;
        logic [BB-1:0]     bank;
        logic [BB-1:0]     widx;
        logic [LGW-1:0]    lg;
        logic [RW-1:0]     row;
        logic [DATA_W-1:0] wdata;
        logic              rsp_v;
        logic              rsp_l;
        logic [DATA_W-1:0] rsp_d;
    } seq_t;

    seq_t q, d;

    logic [LGW-1:0]   lg_req;
    logic [BB-1:0]    req_bank;
    logic [BB-1:0]    base_bank;
    logic [NBANK-1:0] need;
    logic [NBANK-1:0] line_mask;
    logic [BB-1:0]    rd_sel;
    logic [BB-1:0]    last_idx;
    logic             accept;

    // request decode: length clamp, aligned base, banks the request needs
    always_comb begin
        lg_req    = (int'(req_len) > BB) ? LGW'(BB) : LGW'(req_len);
        req_bank  = req_addr[BB-1:0];
        base_bank = req_bank & ~BB'((1 << lg_req) - 1);
        for (int b = 0; b < NBANK; b++) begin
            need[b] = req_write ? (req_bank == BB'(b))
                                : ((b >> lg_req) == (int'(req_bank) >> lg_req));
        end
        req_ready = (q.phase == PH_IDLE) && ((need & bank_busy) == '0);
        accept    = req_valid && req_ready;
    end

    // banks covered by the registered line
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            line_mask[b] = ((b >> q.lg) == (int'(q.bank) >> q.lg));
        end
        rd_sel   = q.bank + q.widx;
        last_idx = BB'((1 << q.lg) - 1);
    end

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        d.rsp_l = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (accept) begin
                    d.phase = PH_ADDR;
                    d.cnt   = CW'(ADDR_CYC - 1);
                    d.we    = req_write;
                    d.lg    = req_write ? '0 : lg_req;
                    d.bank  = req_write ? req_bank : base_bank;
                    d.widx  = '0;
                    d.row   = req_addr[ADDR_W-1:BB];
                    d.wdata = req_wdata;
                end
            end
            PH_ADDR: begin
                if (q.cnt == '0) begin
                    d.phase = q.we ? PH_IDLE : PH_ACCESS;
                    d.cnt   = CW'(ACC_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_ACCESS: begin
                if (q.cnt == '0) begin
                    d.phase = PH_XFER;
                    d.cnt   = CW'(XFER_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_XFER: begin
                if (q.cnt == '0) begin
                    d.rsp_v = 1'b1;
                    d.rsp_d = bank_rdata[rd_sel];
                    d.rsp_l = (q.widx == last_idx);
                    if (q.widx == last_idx) begin
                        d.phase = PH_IDLE;
                    end else begin
                        d.widx = q.widx + 1'b1;
                        d.cnt  = CW'(XFER_CYC - 1);
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign issue_mask  = (q.phase == PH_ADDR && q.cnt == '0) ? line_mask : '0;
    assign issue_we    = q.we;
    assign issue_row   = q.row;
    assign issue_wdata = q.wdata;
    assign rsp_valid   = q.rsp_v;
    assign rsp_data    = q.rsp_d;
    assign rsp_last    = q.rsp_l;

    // R4: the last flag only rides on a presented word
    assert_last_with_word_R4: assert property (
        @(posedge clk) disable iff (!rst_n) rsp_last |-> rsp_valid);

    // R10: no request taken while a line is still returning
    assert_hold_during_line_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_last) |-> !req_ready);

    // R3: each word strobe lasts one cycle
    generate
        if (XFER_CYC > 1) begin : g_gap
            assert_single_cycle_strobe_R3: assert property (
                @(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
        end
    endgenerate

endmodule

// File: rtl/interleaved_mem.sv
module interleaved_mem #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NBANK    = 4,
    parameter int LEN_W    = 2,
    parameter int ADDR_CYC = 4,
    parameter int ACC_CYC  = 24,
    parameter int XFER_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last
);
    localparam int BB    = $clog2(NBANK);
    localparam int RW    = ADDR_W - BB;
    localparam int DEPTH = 1 << RW;

    logic [NBANK-1:0]             bank_busy;
    logic [NBANK-1:0][DATA_W-1:0] bank_rdata;
    logic [NBANK-1:0]             issue_mask;
    logic                         issue_we;
    logic [RW-1:0]                issue_row;
    logic [DATA_W-1:0]            issue_wdata;

    ilv_seq #(
        .NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .bank_busy(bank_busy), .bank_rdata(bank_rdata),
        .issue_mask(issue_mask), .issue_we(issue_we),
        .issue_row(issue_row), .issue_wdata(issue_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            ilv_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ACC_CYC(ACC_CYC)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .issue(issue_mask[g]), .issue_we(issue_we),
                .row(issue_row), .wdata(issue_wdata),
                .busy(bank_busy[g]), .rdata(bank_rdata[g])
            );
        end
    endgenerate

endmodule

// File: tb/interleaved_mem_bench.sv
`timescale 1ns/100ps
module interleaved_mem_bench;
    localparam int A_CYC = 4, C_CYC = 24, X_CYC = 4, WORDS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_last;
    logic [31:0] rsp_data;

    always #2 clk = ~clk;

    interleaved_mem u_interleaved_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] ref_mem [WORDS];
    int bank_free [4];
    int ctrl_free = 0;

    function automatic int word_lat(int k);
        return A_CYC + C_CYC + X_CYC * (k + 1);
    endfunction
    function automatic int line_len(int code);
        return (code >= 2) ? 4 : (1 << code);
    endfunction
    function automatic int line_base(int addr, int code);
        return addr & ~(line_len(code) - 1);
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // drive one request, return the accepting edge; the model checks when it was taken
    task automatic send(bit wr, int addr, int code, logic [31:0] wd, string gtag, output int acc);
        int drive_edge, n, base, expect_acc, g;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 8'(addr);
        req_len = 2'(code); req_wdata = wd;
        drive_edge = cyc + 1;
        n    = wr ? 1 : line_len(code);
        base = wr ? addr : line_base(addr, code);
        expect_acc = (drive_edge > ctrl_free) ? drive_edge : ctrl_free;
        for (int k = 0; k < n; k++)
            if (bank_free[(base + k) % 4] > expect_acc) expect_acc = bank_free[(base + k) % 4];
        g = 0;
        #1;
        while (!req_ready && g < 2000) begin
            @(negedge clk); #1; g++;
        end
        @(posedge clk); #1;
        acc = cyc;
        req_valid = 1'b0;
        chk(acc == expect_acc, gtag, "accept edge", acc, expect_acc);
        for (int k = 0; k < n; k++) bank_free[(base + k) % 4] = acc + A_CYC + C_CYC + 1;
        ctrl_free = wr ? acc + A_CYC + 1 : acc + word_lat(n - 1) + 1;
    endtask

    task automatic do_write(int addr, logic [31:0] wd, string gtag);
        int acc;
        send(1'b1, addr, 0, wd, gtag, acc);
        ref_mem[addr] = wd;
    endtask

    task automatic do_read(int addr, int code, string dtag, string gtag);
        int acc, n, base, g;
        send(1'b0, addr, code, 32'h0, gtag, acc);
        n = line_len(code);
        base = line_base(addr, code);
        for (int k = 0; k < n; k++) begin
            g = 0;
            @(negedge clk);
            while (!rsp_valid && g < 500) begin @(negedge clk); g++; end
            chk(cyc - acc == word_lat(k), "R3", "word latency", cyc - acc, word_lat(k));
            chk(rsp_data == ref_mem[base + k], dtag, "word data", rsp_data, ref_mem[base + k]);
            chk(rsp_last == (k == n - 1), "R4", "last flag", rsp_last, k == n - 1);
        end
    endtask

    // watchdog: counts as a failed check and still prints the summary
    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            total++; bad++;
            $display("FAIL R3 watchdog actual=%0d expected<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int b = 0; b < 4; b++) bank_free[b] = 0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R9", "valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9", "after reset", {req_ready, rsp_valid}, 2'b10);

        // fill: consecutive writes rotate banks; reuse after four stalls (R5, R6)
        for (int a = 0; a < WORDS; a++) do_write(a, $urandom, "R5");

        do_read(5, 0, "R2", "R10");          // R3: 32 edges
        do_read(6, 1, "R2", "R10");          // R3: 36 edges
        do_read(8, 2, "R2", "R10");          // R3: 44 edges
        do_read(9, 2, "R7", "R10");          // R7: unaligned start -> line 8..11
        do_read(14, 3, "R8", "R10");         // R8: code 3 -> four words 12..15
        do_write(20, 32'hA5A5_0001, "R5");
        do_write(24, 32'hA5A5_0002, "R5");   // R5: same bank, held 29 edges
        do_write(21, 32'hA5A5_0003, "R6");
        do_write(22, 32'hA5A5_0004, "R6");   // R6: other bank, taken 5 edges later
        do_write(4, 32'h1234_5678, "R6");
        do_read(0, 0, "R1", "R10");          // R1: row 1 of bank 0 leaves row 0 alone
        do_read(4, 0, "R1", "R10");
        do_write(34, 32'hCAFE_F00D, "R6");
        do_read(32, 2, "R2", "R10");         // R10: line waits for bank 2, sees new word

        for (int i = 0; i < 300; i++) begin
            int a = $urandom_range(WORDS - 1);
            if ($urandom_range(9) < 4) do_write(a, $urandom, "R5");
            else do_read(a, $urandom_range(3), "R2", "R10");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule